// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This block applies decimal correction to the result of a preceding binary add, subtract or multiply, or prepares a decimal operand for a following divide. It is purely combinational. The operand is held as a low byte and a high byte, and the two flags it uses are a carry flag and an auxiliary (half) carry flag. An operation selector picks one of six corrections. Each produces the adjusted bytes and updated flags in the same cycle.

Two of the corrections work on unpacked digits, one digit per byte in the low nibble. The ASCII form of such a digit, with 3h in the high nibble, gives the same results. These two may carry or borrow into the high byte. Two more convert between a binary byte and a tens/units digit pair for multiply and divide. The last two correct a packed byte that holds two BCD digits. The arithmetic that comes before or after the adjustment lies outside this unit.

Top module: `decimal_adjust_unit`

## Requirements
- R1: With opSel = 0 (unpacked adjust after addition), if the low nibble of loIn is above 9 or auxIn is 1, then hiOut = hiIn + 1 (mod 256), loOut = (loIn + 6) & 0Fh, and carryOut = auxOut = 1. For example, hi:lo 00h:6Ah gives 01h:00h.
- R2: With opSel = 0 or 1, when neither correction condition holds, carryOut = auxOut = 0, hiOut = hiIn, and loOut = loIn & 0Fh.
- R3: With opSel = 1 (unpacked adjust after subtraction), if the low nibble of loIn is above 9 or auxIn is 1, then hiOut = hiIn - 1 (mod 256), loOut = (loIn - 6) & 0Fh, and carryOut = auxOut = 1. For example, 00h:FFh gives FFh:09h.
- R4: With opSel = 2 (adjust after multiplication), hiOut = loIn / 10 and loOut = loIn mod 10. For example, loIn 1Eh gives 03h:00h.
- R5: With opSel = 3 (adjust before division), loOut = (hiIn * 10 + loIn) mod 256 and hiOut = 0. For example, 03h:07h gives 00h:25h.
- R6: With opSel = 4 (packed adjust after addition), 6 is first added when the low nibble is above 9 or auxIn is 1, and auxOut is set exactly in that case. Then 60h is added when the original loIn is above 99h or carryIn is 1, and carryOut is set exactly in that case. For example, 7Dh gives 83h.
- R7: With opSel = 5 (packed adjust after subtraction), the same two conditions subtract 6 and then 60h and set auxOut and carryOut in the same way. For example, 3Dh gives 37h.
- R8: With opSel = 4 or 5, hiOut = hiIn.
- R9: With opSel = 2 or 3, carryOut = carryIn and auxOut = auxIn.
- R10: With opSel = 6 or 7 (unused codes), every output equals its corresponding input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 3 | Adjustment selector, codes 0 to 5, with 6 and 7 unused |
| loIn | input | 8 | Low byte of the operand |
| hiIn | input | 8 | High byte of the operand |
| carryIn | input | 1 | Carry flag before adjustment |
| auxIn | input | 1 | Auxiliary (half) carry flag before adjustment |
| loOut | output | 8 | Adjusted low byte |
| hiOut | output | 8 | Adjusted high byte |
| carryOut | output | 1 | Carry flag after adjustment |
| auxOut | output | 1 | Auxiliary flag after adjustment |

## Verification
The assertions check structural invariants whenever the inputs change:
- the unpacked adjusts leave a clear upper nibble and move carry and auxiliary together;
- the multiply split keeps the units digit below ten;
- the divide preparation clears the high byte;
- the packed adjusts leave the high byte untouched;
- the unused codes pass the inputs through.

The exact corrected values, the choice between the ±6 and ±60h corrections, and the wraparound of the high byte at 00h and FFh can only be shown by the bench. It compares every output against a reference model on both the worked examples and a broad sweep of operands and flags.

// File: rtl/decimal_adjust_pkg.sv
package decimal_adjust_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int RADIX  = 10;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_UNPK = 3'd0,
    OP_SUB_UNPK = 3'd1,
    OP_MUL_SPLT = 3'd2,
    OP_DIV_PREP = 3'd3,
    OP_ADD_PACK = 3'd4,
    OP_SUB_PACK = 3'd5
  } adjOp_e;

  typedef struct packed {
    logic unpackAdj;
    logic packAdj;
    logic subtract;
    logic mulSplit;
    logic divPrep;
  } adjCtl_t;
endpackage

// File: rtl/decimal_adjust_ctrl.sv
module decimal_adjust_ctrl
  import decimal_adjust_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output adjCtl_t         ctl
);
  always_comb begin
    ctl = '0;
    case (opSel)
      OP_ADD_UNPK: ctl.unpackAdj = 1'b1;
      OP_SUB_UNPK: begin ctl.unpackAdj = 1'b1; ctl.subtract = 1'b1; end
      OP_MUL_SPLT: ctl.mulSplit = 1'b1;
      OP_DIV_PREP: ctl.divPrep = 1'b1;
      OP_ADD_PACK: ctl.packAdj = 1'b1;
      OP_SUB_PACK: begin ctl.packAdj = 1'b1; ctl.subtract = 1'b1; end
      default:     ctl = '0;
    endcase
  end
endmodule

// File: rtl/decimal_adjust_dp.sv
module decimal_adjust_dp
  import decimal_adjust_pkg::*;
(
  input  adjCtl_t           ctl,
  input  logic [BYTE_W-1:0] loIn,
  input  logic [BYTE_W-1:0] hiIn,
  input  logic              carryIn,
  input  logic              auxIn,
  output logic [BYTE_W-1:0] loOut,
  output logic [BYTE_W-1:0] hiOut,
  output logic              carryOut,
  output logic              auxOut
);
  localparam logic [BYTE_W-1:0] NIB_FIX  = BYTE_W'(RADIX) ^ BYTE_W'(RADIX) ^ BYTE_W'(6);
  localparam logic [BYTE_W-1:0] BYTE_FIX = NIB_FIX << NIB_W;
  localparam logic [BYTE_W-1:0] PACK_MAX = BYTE_W'(8'h99);
  localparam logic [BYTE_W-1:0] RAD_B    = BYTE_W'(RADIX);
  localparam logic [NIB_W-1:0]  NIB_MAX  = NIB_W'(RADIX - 1);

  logic              lowNibBad;
  logic              byteBad;
  logic [BYTE_W-1:0] nibStep;
  logic [BYTE_W-1:0] byteStep;
  logic [BYTE_W-1:0] prodSum;

  assign lowNibBad = (loIn[NIB_W-1:0] > NIB_MAX) || auxIn;
  assign byteBad   = (loIn > PACK_MAX) || carryIn;
  assign prodSum   = BYTE_W'(hiIn * RAD_B) + loIn;

  always_comb begin
    loOut    = loIn;
    hiOut    = hiIn;
    carryOut = carryIn;
    auxOut   = auxIn;
    nibStep  = loIn;
    byteStep = loIn;
    if (ctl.unpackAdj) begin
      if (lowNibBad) begin
        nibStep  = ctl.subtract ? loIn - NIB_FIX : loIn + NIB_FIX;
        hiOut    = ctl.subtract ? hiIn - 1'b1 : hiIn + 1'b1;
        carryOut = 1'b1;
        auxOut   = 1'b1;
      end else begin
        carryOut = 1'b0;
        auxOut   = 1'b0;
      end
      loOut = {{(BYTE_W-NIB_W){1'b0}}, nibStep[NIB_W-1:0]};
    end else if (ctl.packAdj) begin
      if (lowNibBad) nibStep = ctl.subtract ? loIn - NIB_FIX : loIn + NIB_FIX;
      auxOut   = lowNibBad;
      byteStep = nibStep;
      if (byteBad) byteStep = ctl.subtract ? nibStep - BYTE_FIX : nibStep + BYTE_FIX;
      carryOut = byteBad;
      loOut    = byteStep;
    end else if (ctl.mulSplit) begin
      hiOut = loIn / RAD_B;
      loOut = loIn % RAD_B;
    end else if (ctl.divPrep) begin
      hiOut = '0;
      loOut = prodSum;
    end
  end
endmodule

// File: rtl/decimal_adjust_unit.sv
module decimal_adjust_unit
  import decimal_adjust_pkg::*;
(
  input  logic [2:0] opSel,
  input  logic [7:0] loIn,
  input  logic [7:0] hiIn,
  input  logic       carryIn,
  input  logic       auxIn,
  output logic [7:0] loOut,
  output logic [7:0] hiOut,
  output logic       carryOut,
  output logic       auxOut
);
  adjCtl_t ctl;

  decimal_adjust_ctrl u_ctrl (.opSel(opSel), .ctl(ctl));

  decimal_adjust_dp u_dp (
    .ctl(ctl), .loIn(loIn), .hiIn(hiIn), .carryIn(carryIn), .auxIn(auxIn),
    .loOut(loOut), .hiOut(hiOut), .carryOut(carryOut), .auxOut(auxOut)
  );
endmodule

// File: rtl/decimal_adjust_unit_chk.sv
module decimal_adjust_unit_chk (
  input logic [2:0] opSel,
  input logic [7:0] loIn,
  input logic [7:0] hiIn,
  input logic       carryIn,
  input logic       auxIn,
  input logic [7:0] loOut,
  input logic [7:0] hiOut,
  input logic       carryOut,
  input logic       auxOut
);
  always_comb begin
    if (opSel == 3'd0 || opSel == 3'd1) begin
      // R2
      unpack_nibble_chk: assert (loOut[7:4] == 4'h0) else $error("unpacked high nibble set");
      // R1
      unpack_flags_chk: assert (carryOut == auxOut) else $error("unpacked flags differ");
    end
    if (opSel == 3'd1 && carryOut) begin
      // R3
      sub_borrow_chk: assert (hiOut == hiIn - 8'd1) else $error("high byte not decremented");
    end
    if (opSel == 3'd2) begin
      // R4
      mul_units_chk: assert (loOut < 8'd10) else $error("units digit out of range");
    end
    if (opSel == 3'd3) begin
      // R5
      div_high_chk: assert (hiOut == 8'h00) else $error("high byte not cleared");
    end
    if (opSel == 3'd2 || opSel == 3'd3) begin
      // R9
      conv_flags_chk: assert (carryOut == carryIn && auxOut == auxIn) else $error("flags altered");
    end
    if (opSel == 3'd4 || opSel == 3'd5) begin
      // R8
      pack_high_chk: assert (hiOut == hiIn) else $error("high byte altered");
    end
    if (opSel > 3'd5) begin
      // R10
      unused_pass_chk: assert (loOut == loIn && hiOut == hiIn && carryOut == carryIn && auxOut == auxIn)
        else $error("unused code altered outputs");
    end
  end
endmodule

bind decimal_adjust_unit decimal_adjust_unit_chk u_chk (.*);

// File: tb/decimal_adjust_unit_bench.sv
module decimal_adjust_unit_bench;
  logic       clk = 1'b0;
  logic [2:0] opSel = 3'd0;
  logic [7:0] loIn = 8'h00, hiIn = 8'h00;
  logic       carryIn = 1'b0, auxIn = 1'b0;
  logic [7:0] loOut, hiOut;
  logic       carryOut, auxOut;
  int         tests = 0, fails = 0;

  always #5 clk = ~clk;

  decimal_adjust_unit u_decimal_adjust_unit (
    .opSel(opSel), .loIn(loIn), .hiIn(hiIn), .carryIn(carryIn), .auxIn(auxIn),
    .loOut(loOut), .hiOut(hiOut), .carryOut(carryOut), .auxOut(auxOut)
  );

  function automatic string reqOf(int op, int c, int a, int lo);
    case (op)
      0: return ((lo % 16) > 9 || a != 0) ? "R1" : "R2";
      1: return ((lo % 16) > 9 || a != 0) ? "R3" : "R2";
      2: return "R4 R9";
      3: return "R5 R9";
      4: return "R6 R8";
      5: return "R7 R8";
      default: return "R10";
    endcase
  endfunction

  // Reference model on integers: returns {hi, lo, c, a}
  function automatic logic [17:0] model(int op, int lo, int hi, int c, int a);
    int nlo = lo, nhi = hi, nc = c, na = a;
    int low = lo % 16;
    if (op == 0 || op == 1) begin
      if (low > 9 || a != 0) begin
        nlo = (op == 0) ? lo + 6 : lo - 6;
        nhi = (op == 0) ? hi + 1 : hi - 1;
        nc = 1; na = 1;
      end else begin nc = 0; na = 0; end
      nlo = ((nlo % 256) + 256) % 16;
    end else if (op == 2) begin
      nhi = lo / 10; nlo = lo % 10;
    end else if (op == 3) begin
      nlo = hi * 10 + lo; nhi = 0;
    end else if (op == 4 || op == 5) begin
      int sgn = (op == 4) ? 1 : -1;
      na = (low > 9 || a != 0) ? 1 : 0;
      nc = (lo > 153 || c != 0) ? 1 : 0;
      nlo = lo + sgn * 6 * na + sgn * 96 * nc;
    end
    nlo = ((nlo % 256) + 256) % 256;
    nhi = ((nhi % 256) + 256) % 256;
    return {nhi[7:0], nlo[7:0], nc[0], na[0]};
  endfunction

  task automatic apply(input int op, input int lo, input int hi, input int c, input int a);
    logic [17:0] exp;
    @(posedge clk);
    opSel = op[2:0]; loIn = lo[7:0]; hiIn = hi[7:0]; carryIn = c[0]; auxIn = a[0];
    @(negedge clk);
    exp = model(op, lo, hi, c, a);
    tests++;
    if ({hiOut, loOut, carryOut, auxOut} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d in=%02h:%02h c=%0d a=%0d actual=%02h:%02h c=%0d a=%0d expected=%02h:%02h c=%0d a=%0d",
               reqOf(op, c, a, lo), op, hi, lo, c, a, hiOut, loOut, carryOut, auxOut,
               exp[17:10], exp[9:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // Reset-state check: all-zero inputs on the unpacked add
    apply(0, 8'h00, 8'h00, 0, 0);    // R2
    apply(0, 8'h6A, 8'h00, 0, 0);    // R1: 006A -> 0100
    apply(0, 8'h35, 8'hFF, 0, 1);    // R1: aux forces, high wraps to 00
    apply(0, 8'h39, 8'h02, 1, 0);    // R2: ASCII digit, no correction
    apply(1, 8'hFF, 8'h00, 0, 0);    // R3: 00FF -> FF09
    apply(1, 8'h02, 8'h05, 0, 1);    // R3: aux-driven borrow
    apply(1, 8'h07, 8'h00, 1, 0);    // R2: no correction, flags cleared
    apply(2, 8'h1E, 8'h00, 0, 0);    // R4: 001E -> 0300
    apply(2, 8'hFF, 8'h7A, 1, 1);    // R4 R9: 255 -> 25:05, flags kept
    apply(3, 8'h07, 8'h03, 0, 0);    // R5: 0307 -> 0025
    apply(3, 8'h09, 8'h63, 1, 0);    // R5 R9: truncated product
    apply(4, 8'h7D, 8'h12, 0, 0);    // R6 R8: 7D -> 83
    apply(4, 8'h9A, 8'h00, 0, 0);    // R6: both corrections, carry
    apply(4, 8'h12, 8'h00, 1, 0);    // R6: carry-in forces 60h
    apply(5, 8'h3D, 8'h44, 0, 0);    // R7 R8: 3D -> 37
    apply(5, 8'hA0, 8'h00, 0, 1);    // R7: both corrections
    apply(6, 8'hAB, 8'hCD, 1, 0);    // R10
    apply(7, 8'h5F, 8'h01, 0, 1);    // R10
    for (int op = 0; op < 8; op++) begin
      for (int n = 0; n < 400; n++) begin
        apply(op, $urandom % 256, $urandom % 256, $urandom % 2, $urandom % 2);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule